// File: doc/BRIEF.md
# Video Black-Level Clamp Controller

This block holds the black level of one digitized video channel at a chosen code. On every line it gathers the ADC samples that fall inside a back-porch clamp window. When the window closes it compares the mean of those samples with a target level. It then issues a single up or down command to an external charge path, which adjusts the DC level of the input coupling capacitor. A mean that lies within one code of the target produces no command.

The target is either a per-channel default or a programmed level. The default is code 64 for luma or composite channels and code 128 for chroma channels. A programmed level is forced into the range 1 to 254. While vertical blanking is flagged, all clamp activity is frozen. A status output reports lock once several consecutive lines have landed inside the dead band.

Top module: `video_clamp_ctrl`

## Requirements
- R1: While and directly after reset, `clamp_up`, `clamp_dn` and `locked` are 0.
- R2: With `tgt_prog_en` = 0 and `chroma_sel` = 0, the target is code 64.
- R3: With `tgt_prog_en` = 0 and `chroma_sel` = 1, the target is code 128.
- R4: With `tgt_prog_en` = 1, the target is `tgt_level`, except that 0 becomes 1 and 255 becomes 254.
- R5: A sample is accumulated only on a clock where `clamp_win` = 1 and `vblank` = 0. The decision strobe appears in the cycle after the first clock edge at which `clamp_win` is seen low after being high.
- R6: Let mean be the exact mean of the accumulated samples and T the target. If mean < T-1, `clamp_up` pulses. If mean > T+1, `clamp_dn` pulses. Otherwise neither pulses.
- R7: `clamp_up` and `clamp_dn` are never high together, and each pulse lasts exactly one clock cycle.
- R8: If `vblank` = 1 at the window-closing edge, no strobe is issued, the accumulated samples are discarded, and the lock count is left unchanged.
- R9: `locked` rises after 8 consecutive in-band decisions and falls together with any up or down strobe.
- R10: A window in which no sample was accumulated issues no strobe and leaves the lock state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample | input | 8 | ADC sample, one per clock |
| clamp_win | input | 1 | Back-porch clamp window |
| vblank | input | 1 | Vertical blanking freeze flag |
| chroma_sel | input | 1 | 1 = channel carries chroma |
| tgt_prog_en | input | 1 | 1 = use the programmed target |
| tgt_level | input | 8 | Programmed target level |
| clamp_up | output | 1 | One-cycle raise-level command |
| clamp_dn | output | 1 | One-cycle lower-level command |
| locked | output | 1 | Black level settled |

## Verification
The bench drives means that sit exactly on the dead-band edges (T-1 and T+1) and half a code beyond them. A comparator with an off-by-one error, or one that truncates the mean, would issue strobes on the edge cases or miss the half-code cases. Programmed targets of 0 and 255 probe the saturation. An unsaturated design would compare against 0 or 255 and strobe wrongly on the boundary samples. Freeze tests cover two situations: vblank high at the window end, and vblank covering the whole window. A design that leaks frozen samples or counts empty lines would strobe or shift the lock count. Runs of 7 and then 8 in-band lines, followed by one outlier, show whether lock is declared one line early or late, or fails to clear.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD = 2'b00,
    DEC_RAISE = 2'b01,
    DEC_LOWER = 2'b10
  } clamp_dec_e;
endpackage

// File: rtl/clamp_target_sel.sv
module clamp_target_sel #(
  parameter int DATA_W     = 8,
  parameter int LUMA_TGT   = 64,
  parameter int CHROMA_TGT = 128
) (
  input  logic              prog_en,
  input  logic [DATA_W-1:0] prog_level,
  input  logic              chroma_sel,
  output logic [DATA_W-1:0] target
);
  localparam logic [DATA_W-1:0] MAXCODE = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] LO_LIM  = DATA_W'(1);
  localparam logic [DATA_W-1:0] HI_LIM  = MAXCODE - DATA_W'(1);

  logic [DATA_W-1:0] prog_sat;

  always_comb begin
    if (prog_level < LO_LIM)      prog_sat = LO_LIM;
    else if (prog_level > HI_LIM) prog_sat = HI_LIM;
    else                          prog_sat = prog_level;
  end

  always_comb begin
    if (prog_en)         target = prog_sat;
    else if (chroma_sel) target = DATA_W'(CHROMA_TGT);
    else                 target = DATA_W'(LUMA_TGT);
  end
endmodule

// File: rtl/clamp_window_accum.sv
module clamp_window_accum #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       sample,
  input  logic                    win,
  input  logic                    freeze,
  output logic                    fire,
  output logic [DATA_W+CNT_W-1:0] sum,
  output logic [CNT_W-1:0]        cnt
);
  localparam int SUM_W = DATA_W + CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             win_q, win_d;
  logic [SUM_W-1:0] sum_d;
  logic [CNT_W-1:0] cnt_d;
  logic             win_close;
  logic             take;

  assign win_close = win_q & ~win;
  assign take      = win & ~freeze & (cnt != CNT_MAX);
  assign fire      = win_close & ~freeze & (cnt != '0);

  always_comb begin
    win_d = win;
    sum_d = sum;
    cnt_d = cnt;
    if (win_close) begin
      sum_d = '0;
      cnt_d = '0;
    end else if (take) begin
      sum_d = sum + SUM_W'(sample);
      cnt_d = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      sum   <= '0;
      cnt   <= '0;
    end else begin
      win_q <= win_d;
      sum   <= sum_d;
      cnt   <= cnt_d;
    end
  end
endmodule

// File: rtl/clamp_decide.sv
module clamp_decide
  import clamp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic [DATA_W+CNT_W-1:0] sum,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [DATA_W-1:0]       target,
  output logic                    in_band,
  output logic                    up,
  output logic                    dn
);
  localparam int PW = DATA_W + CNT_W + 1;

  logic [DATA_W:0] tgt_m1, tgt_p1;
  logic [PW-1:0]   lo_bound, hi_bound, sum_x;
  clamp_dec_e      dec;
  logic            up_d, dn_d;

  assign tgt_m1 = {1'b0, target} - (DATA_W+1)'(1);
  assign tgt_p1 = {1'b0, target} + (DATA_W+1)'(1);

  always_comb begin
    sum_x    = PW'(sum);
    lo_bound = PW'(tgt_m1) * PW'(cnt);
    hi_bound = PW'(tgt_p1) * PW'(cnt);
    if (sum_x < lo_bound)      dec = DEC_RAISE;
    else if (sum_x > hi_bound) dec = DEC_LOWER;
    else                       dec = DEC_HOLD;
  end

  assign in_band = (dec == DEC_HOLD);

  always_comb begin
    up_d = fire && (dec == DEC_RAISE);
    dn_d = fire && (dec == DEC_LOWER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_d;
      dn <= dn_d;
    end
  end
endmodule

// File: rtl/clamp_lock.sv
module clamp_lock #(
  parameter int LOCK_LINES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic in_band,
  output logic locked
);
  localparam int LW = $clog2(LOCK_LINES + 1);
  localparam logic [LW-1:0] LIM = LW'(LOCK_LINES);

  logic [LW-1:0] run_q, run_d;
  logic          run_en;

  assign run_en = fire;

  always_comb begin
    run_d = run_q;
    if (!in_band)         run_d = '0;
    else if (run_q < LIM) run_d = run_q + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign locked = (run_q == LIM);
endmodule

// File: rtl/video_clamp_ctrl.sv
module video_clamp_ctrl #(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int LUMA_TGT   = 64,
  parameter int CHROMA_TGT = 128,
  parameter int LOCK_LINES = 8,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample,
  input  logic              clamp_win,
  input  logic              vblank,
  input  logic              chroma_sel,
  input  logic              tgt_prog_en,
  input  logic [DATA_W-1:0] tgt_level,
  output logic              clamp_up,
  output logic              clamp_dn,
  output logic              locked
);
  localparam int SUM_W = DATA_W + CNT_W;

  logic [SYNC_STG-1:0] rst_pipe;
  logic                rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STG-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_STG-1];

  logic [DATA_W-1:0] target;
  logic              fire, in_band;
  logic [SUM_W-1:0]  sum;
  logic [CNT_W-1:0]  cnt;

  clamp_target_sel #(
    .DATA_W(DATA_W), .LUMA_TGT(LUMA_TGT), .CHROMA_TGT(CHROMA_TGT)
  ) u_tsel (
    .prog_en(tgt_prog_en), .prog_level(tgt_level),
    .chroma_sel(chroma_sel), .target(target)
  );

  clamp_window_accum #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_core_n), .sample(sample), .win(clamp_win),
    .freeze(vblank), .fire(fire), .sum(sum), .cnt(cnt)
  );

  clamp_decide #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_core_n), .fire(fire), .sum(sum), .cnt(cnt),
    .target(target), .in_band(in_band), .up(clamp_up), .dn(clamp_dn)
  );

  clamp_lock #(.LOCK_LINES(LOCK_LINES)) u_lock (
    .clk(clk), .rst_n(rst_core_n), .fire(fire), .in_band(in_band),
    .locked(locked)
  );
endmodule

// File: rtl/video_clamp_ctrl_chk.sv
module video_clamp_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic clamp_win,
  input logic vblank,
  input logic clamp_up,
  input logic clamp_dn,
  input logic locked
);
  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(clamp_up && clamp_dn));

  assert_up_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_up |=> !clamp_up);

  assert_dn_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_dn |=> !clamp_dn);

  assert_strobe_after_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_up || clamp_dn) |-> (!$past(clamp_win) && $past(clamp_win, 2)));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vblank) |-> (!clamp_up && !clamp_dn));

  assert_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_up || clamp_dn) |-> !locked);
endmodule

bind video_clamp_ctrl video_clamp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clamp_win(clamp_win), .vblank(vblank),
  .clamp_up(clamp_up), .clamp_dn(clamp_dn), .locked(locked)
);

// File: tb/video_clamp_ctrl_tb.sv
module video_clamp_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] sample;
  logic       clamp_win, vblank, chroma_sel, tgt_prog_en;
  logic [7:0] tgt_level;
  logic       clamp_up, clamp_dn, locked;

  always #4 clk = ~clk;

  video_clamp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sample(sample), .clamp_win(clamp_win),
    .vblank(vblank), .chroma_sel(chroma_sel), .tgt_prog_en(tgt_prog_en),
    .tgt_level(tgt_level), .clamp_up(clamp_up), .clamp_dn(clamp_dn),
    .locked(locked)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural reference
  int m_sum, m_cnt, m_run;
  bit m_pw, e_up, e_dn;

  function automatic int ref_target();
    if (tgt_prog_en) begin
      if (tgt_level == 0) return 1;
      if (tgt_level == 255) return 254;
      return int'(tgt_level);
    end
    return chroma_sel ? 128 : 64;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sum = 0; m_cnt = 0; m_run = 0; m_pw = 0; e_up = 0; e_dn = 0;
    end else begin
      e_up = 0; e_dn = 0;
      if (m_pw && !clamp_win) begin
        if (!vblank && m_cnt > 0) begin
          int t;
          t = ref_target();
          if (m_sum < (t - 1) * m_cnt)      e_up = 1;
          else if (m_sum > (t + 1) * m_cnt) e_dn = 1;
          if (e_up || e_dn) m_run = 0;
          else if (m_run < 8) m_run++;
        end
        m_sum = 0; m_cnt = 0;
      end else if (clamp_win && !vblank && m_cnt < 255) begin
        m_sum += int'(sample);
        m_cnt++;
      end
      m_pw = clamp_win;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(clamp_up == e_up, "R6", "model clamp_up", int'(clamp_up), int'(e_up));
      chk(clamp_dn == e_dn, "R6", "model clamp_dn", int'(clamp_dn), int'(e_dn));
      chk(locked == (m_run >= 8), "R9", "model locked", int'(locked), int'(m_run >= 8));
    end
  end

  // one line: alternating samples a,b for len cycles, hand-computed result
  task automatic line(int a, int b, int len, bit eu, bit ed, bit vb_end, string tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      clamp_win = 1'b1;
      sample = 8'((i % 2) ? b : a);
    end
    @(negedge clk);
    clamp_win = 1'b0;
    sample = 8'd0;
    vblank = vb_end;
    @(negedge clk);
    chk(clamp_up == eu, tag, "line clamp_up", int'(clamp_up), int'(eu));
    chk(clamp_dn == ed, tag, "line clamp_dn", int'(clamp_dn), int'(ed));
    vblank = 1'b0;
    @(negedge clk);
    chk(!clamp_up && !clamp_dn, "R7", "strobe width", int'(clamp_up | clamp_dn), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sample = '0; clamp_win = 0; vblank = 0;
    chroma_sel = 0; tgt_prog_en = 0; tgt_level = '0;
    repeat (3) @(negedge clk);
    chk(!clamp_up && !clamp_dn && !locked, "R1", "reset outputs",
        int'({clamp_up, clamp_dn, locked}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!clamp_up && !clamp_dn && !locked, "R1", "post-reset outputs",
        int'({clamp_up, clamp_dn, locked}), 0);

    // R2 luma default 64
    line(62, 63, 8, 1, 0, 0, "R2 R6 below band");
    line(63, 63, 8, 0, 0, 0, "R2 R6 lower edge");
    line(66, 65, 8, 0, 1, 0, "R2 R6 above band");
    line(65, 65, 6, 0, 0, 0, "R2 R6 upper edge");
    // R3 chroma default 128
    chroma_sel = 1;
    line(126, 127, 8, 1, 0, 0, "R3 below");
    line(130, 129, 4, 0, 1, 0, "R3 above");
    line(128, 128, 4, 0, 0, 0, "R3 centre");
    // R4 saturation of programmed levels
    tgt_prog_en = 1; tgt_level = 8'd0;
    line(0, 0, 4, 0, 0, 0, "R4 low sat edge");
    line(3, 2, 4, 0, 1, 0, "R4 low sat above");
    tgt_level = 8'd255;
    line(255, 255, 4, 0, 0, 0, "R4 high sat edge");
    line(252, 252, 4, 1, 0, 0, "R4 high sat below");
    tgt_level = 8'd100;
    line(97, 98, 4, 1, 0, 0, "R4 mid value");
    // R8 freeze at window close: no strobe though mean is far off
    line(10, 10, 6, 0, 0, 1, "R8 freeze at close");
    // R10 window entirely frozen then closed unfrozen
    vblank = 1;
    line(10, 10, 6, 0, 0, 0, "R10 empty window");
    // R5 samples during vblank inside window excluded
    vblank = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); clamp_win = 1; vblank = (i < 2); sample = (i < 2) ? 8'd0 : 8'd100;
    end
    @(negedge clk); clamp_win = 0; vblank = 0;
    @(negedge clk);
    chk(!clamp_up && !clamp_dn, "R5", "frozen samples excluded",
        int'({clamp_up, clamp_dn}), 0);
    repeat (3) @(negedge clk);

    // R9 lock after 8 in-band lines, cleared on outlier
    tgt_prog_en = 0; chroma_sel = 0;
    line(50, 50, 4, 1, 0, 0, "R9 clear run");
    for (int k = 0; k < 7; k++) line(64, 64, 4, 0, 0, 0, "R9 in band");
    chk(!locked, "R9", "not locked after 7", int'(locked), 0);
    vblank = 1;
    line(0, 0, 4, 0, 0, 1, "R8 frozen keeps run");
    vblank = 0;
    chk(!locked, "R8", "lock held during freeze", int'(locked), 0);
    line(64, 65, 4, 0, 0, 0, "R9 eighth");
    chk(locked, "R9", "locked after 8", int'(locked), 1);
    line(80, 80, 4, 0, 1, 0, "R9 outlier");
    chk(!locked, "R9", "unlock on outlier", int'(locked), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule